// File: doc/BRIEF.md
# Receive FIFO Host Read Port

This block sits between a host register bus and three receive FIFOs. Each FIFO has its own read-only 32-bit data register. A host read of one of these registers takes the word at the head of that FIFO and advances the FIFO by one. If that FIFO is empty, the read still completes. It returns the last word that this port delivered from the same FIFO, and the FIFO is not touched.

The FIFO storage and the receiver that fills it lie outside the block. The FIFOs are show-ahead: the head word is valid whenever the empty flag is low. The block drives a one-cycle pop strobe per FIFO. It keeps a separate hold register for each FIFO and registers the read data, so the data is valid one cycle after the read strobe. A bus-reset input clears every hold register and the read data to zero. A read of any other address in the block's window returns zero and has no side effects.

Top module: `rxrd_port`

## Requirements
- R1: Byte offsets 0x80, 0x84 and 0x88 address FIFO 0, FIFO 1 and FIFO 2 respectively; a read of one of them acts only on that FIFO.
- R2: A read of a mapped register whose FIFO is not empty raises that FIFO's pop bit during the read cycle only and returns the FIFO's head word.
- R3: `rd_valid_o` is high in the cycle after each accepted read, and `rd_data_o` carries that read's result in the same cycle.
- R4: A read of a mapped register whose FIFO is empty raises no pop bit and returns the last word popped from that FIFO.
- R5: Each FIFO has its own hold register; pops from one FIFO never change the value an empty read of another FIFO returns.
- R6: An empty read of a FIFO that has not been popped since the last reset or bus reset returns zero.
- R7: While `bus_reset_i` is high, all hold registers and `rd_data_o` clear to zero, a read in that cycle is dropped (no pop, `rd_valid_o` low next cycle), and `bus_reset_i` has priority over `rd_en_i`.
- R8: A read of any offset other than the three mapped ones returns zero, raises no pop bit and leaves every hold register unchanged.
- R9: No pop bit rises while `rd_en_i` is low, whatever the address and FIFO state; at most one pop bit is high in any cycle.
- R10: After `rst`, `rd_data_o` is zero, `rd_valid_o` is low and every hold register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | Synchronous clear of hold registers and read data |
| rd_en_i | input | 1 | Host read strobe, one cycle per read |
| rd_addr_i | input | 8 | Byte offset of the read within the block window |
| fifo_empty_i | input | 3 | Per-FIFO empty flag |
| fifo_head_i | input | 96 | Per-FIFO head word, FIFO n in bits [32n+31:32n] |
| fifo_pop_o | output | 3 | Per-FIFO pop strobe |
| rd_data_o | output | 32 | Registered read data |
| rd_valid_o | output | 1 | High in the cycle after an accepted read |

## Verification
The assertions assume that each FIFO's head word is stable and meaningful whenever its empty flag is low. They also assume that the FIFO advances exactly once for each cycle in which its pop bit is high. The bench drives a model FIFO per channel that presents a word computed from the channel number and the pop count, and that advances only on an observed pop. Reads are single-cycle strobes driven between clock edges, so the address, enable and empty flags stay steady across each sampling edge.

// File: rtl/rxrd_pkg.sv
package rxrd_pkg;

    localparam int unsigned RXRD_DATA_W   = 32;
    localparam int unsigned RXRD_ADDR_W   = 8;
    localparam int unsigned RXRD_NUM_CH   = 3;
    localparam int unsigned RXRD_BASE     = 'h80;
    localparam int unsigned RXRD_STRIDE   = 4;

    // What a read does this cycle
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,   // no accepted read
        ACC_POP  = 2'd1,   // mapped, FIFO has data
        ACC_HOLD = 2'd2,   // mapped, FIFO empty
        ACC_ZERO = 2'd3    // unmapped offset
    } acc_kind_e;

    // Offset of channel ch for a given base and stride
    function automatic int unsigned ch_offset(input int unsigned base,
                                              input int unsigned stride,
                                              input int unsigned ch);
        return base + ch * stride;
    endfunction

endpackage

// File: rtl/rxrd_decode.sv
module rxrd_decode
    import rxrd_pkg::*;
#(
    parameter int unsigned ADDR_W = RXRD_ADDR_W,
    parameter int unsigned NUM_CH = RXRD_NUM_CH,
    parameter int unsigned BASE   = RXRD_BASE,
    parameter int unsigned STRIDE = RXRD_STRIDE
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              bus_reset,
    input  logic [NUM_CH-1:0] fifo_empty,
    output logic [NUM_CH-1:0] sel,
    output acc_kind_e         kind
);

    logic accept;
    assign accept = rd_en && !bus_reset;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_match
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(ch_offset(BASE, STRIDE, g));
        assign sel[g] = accept && (rd_addr == CH_ADDR);
    end

    always_comb begin
        if (!accept)
            kind = ACC_NONE;
        else if (sel == '0)
            kind = ACC_ZERO;
        else if ((sel & ~fifo_empty) != '0)
            kind = ACC_POP;
        else
            kind = ACC_HOLD;
    end

endmodule

// File: rtl/rxrd_hold.sv
module rxrd_hold
    import rxrd_pkg::*;
#(
    parameter int unsigned DATA_W = RXRD_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              sel,
    input  logic              empty,
    input  logic [DATA_W-1:0] head,
    output logic              pop,
    output logic [DATA_W-1:0] hold_q
);

    assign pop = sel && !empty;

    always_ff @(posedge clk) begin
        if (rst || bus_reset)
            hold_q <= '0;
        else if (pop)
            hold_q <= head;
    end

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);  // R4

    AST_HOLD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (pop && !bus_reset) |=> (hold_q == $past(head)));  // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!pop && !bus_reset) |=> $stable(hold_q));  // R5

    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (hold_q == '0));  // R7

endmodule

// File: rtl/rxrd_resp.sv
module rxrd_resp
    import rxrd_pkg::*;
#(
    parameter int unsigned DATA_W = RXRD_DATA_W,
    parameter int unsigned NUM_CH = RXRD_NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_reset,
    input  acc_kind_e                kind,
    input  logic [NUM_CH-1:0]        sel,
    input  logic [NUM_CH*DATA_W-1:0] heads,
    input  logic [NUM_CH*DATA_W-1:0] holds,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     rd_valid
);

    logic [DATA_W-1:0] head_sel;
    logic [DATA_W-1:0] hold_sel;
    logic [DATA_W-1:0] next_data;

    always_comb begin
        head_sel = '0;
        hold_sel = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel[i]) begin
                head_sel = head_sel | heads[i*DATA_W +: DATA_W];
                hold_sel = hold_sel | holds[i*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        unique case (kind)
            ACC_POP:  next_data = head_sel;
            ACC_HOLD: next_data = hold_sel;
            default:  next_data = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || bus_reset) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= (kind != ACC_NONE);
            if (kind != ACC_NONE)
                rd_data <= next_data;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (kind != ACC_NONE && !bus_reset) |=> rd_valid);  // R3

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_NONE) |=> !rd_valid);  // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_ZERO && !bus_reset) |=> (rd_data == '0));  // R8

    AST_BUSRST_DATA: assert property (@(posedge clk) disable iff (rst)
        bus_reset |=> (rd_data == '0 && !rd_valid));  // R7

endmodule

// File: rtl/rxrd_port.sv
module rxrd_port
    import rxrd_pkg::*;
#(
    parameter int unsigned DATA_W = RXRD_DATA_W,
    parameter int unsigned ADDR_W = RXRD_ADDR_W,
    parameter int unsigned NUM_CH = RXRD_NUM_CH,
    parameter int unsigned BASE   = RXRD_BASE,
    parameter int unsigned STRIDE = RXRD_STRIDE
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_reset_i,
    input  logic                     rd_en_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    input  logic [NUM_CH-1:0]        fifo_empty_i,
    input  logic [NUM_CH*DATA_W-1:0] fifo_head_i,
    output logic [NUM_CH-1:0]        fifo_pop_o,
    output logic [DATA_W-1:0]        rd_data_o,
    output logic                     rd_valid_o
);

    logic [NUM_CH-1:0]        sel;
    acc_kind_e                kind;
    logic [NUM_CH*DATA_W-1:0] holds;

    rxrd_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CH (NUM_CH),
        .BASE   (BASE),
        .STRIDE (STRIDE)
    ) u_decode (
        .rd_en      (rd_en_i),
        .rd_addr    (rd_addr_i),
        .bus_reset  (bus_reset_i),
        .fifo_empty (fifo_empty_i),
        .sel        (sel),
        .kind       (kind)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        rxrd_hold #(
            .DATA_W (DATA_W)
        ) u_hold (
            .clk       (clk),
            .rst       (rst),
            .bus_reset (bus_reset_i),
            .sel       (sel[g]),
            .empty     (fifo_empty_i[g]),
            .head      (fifo_head_i[g*DATA_W +: DATA_W]),
            .pop       (fifo_pop_o[g]),
            .hold_q    (holds[g*DATA_W +: DATA_W])
        );
    end

    rxrd_resp #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .bus_reset (bus_reset_i),
        .kind      (kind),
        .sel       (sel),
        .heads     (fifo_head_i),
        .holds     (holds),
        .rd_data   (rd_data_o),
        .rd_valid  (rd_valid_o)
    );

    AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fifo_pop_o));  // R9

    AST_NO_POP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |-> (fifo_pop_o == '0));  // R9

    AST_NO_POP_BUSRST: assert property (@(posedge clk) disable iff (rst)
        bus_reset_i |-> (fifo_pop_o == '0));  // R7

    AST_POP_VALID: assert property (@(posedge clk) disable iff (rst)
        (fifo_pop_o != '0 && !bus_reset_i) |=> rd_valid_o);  // R3

endmodule

// File: tb/tb_rxrd_port.sv
module tb_rxrd_port;

    localparam int DW = 32;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst;
    logic              bus_reset;
    logic              rd_en;
    logic [7:0]        rd_addr;
    logic [NCH-1:0]    empty;
    logic [NCH*DW-1:0] heads;
    logic [NCH-1:0]    pop;
    logic [DW-1:0]     rd_data;
    logic              rd_valid;

    int total = 0;
    int bad = 0;
    int wr_cnt [NCH];
    int rd_cnt [NCH];
    logic [DW-1:0] hold_m [NCH];

    always #2 clk = ~clk;

    rxrd_port dut (
        .clk          (clk),
        .rst          (rst),
        .bus_reset_i  (bus_reset),
        .rd_en_i      (rd_en),
        .rd_addr_i    (rd_addr),
        .fifo_empty_i (empty),
        .fifo_head_i  (heads),
        .fifo_pop_o   (pop),
        .rd_data_o    (rd_data),
        .rd_valid_o   (rd_valid)
    );

    function automatic logic [DW-1:0] word_of(input int ch, input int idx);
        return {8'(ch + 1), 8'hA5, 16'(idx * 37 + 11)};
    endfunction

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            empty[c] = (wr_cnt[c] == rd_cnt[c]);
            heads[c*DW +: DW] = word_of(c, rd_cnt[c]);
        end
    end

    always @(posedge clk) begin
        for (int c = 0; c < NCH; c++)
            if (pop[c]) rd_cnt[c] <= rd_cnt[c] + 1;
    end

    task automatic chk(input bit ok, input string req,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One host read; checks pop during the read cycle and data the cycle after
    task automatic do_read(input logic [7:0] a, input string req);
        bit mapped;
        int ch;
        logic [NCH-1:0] exp_pop;
        logic [DW-1:0] exp;
        mapped = (a >= 8'h80) && (a < 8'h8C) && (a[1:0] == 2'b00);
        ch = mapped ? (int'(a) - 'h80) / 4 : 0;
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        #1;
        exp_pop = '0;
        exp = '0;
        if (mapped) begin
            if (wr_cnt[ch] != rd_cnt[ch]) begin
                exp_pop = NCH'(1 << ch);
                exp = word_of(ch, rd_cnt[ch]);
                hold_m[ch] = exp;
            end else begin
                exp = hold_m[ch];
            end
        end
        chk(pop == exp_pop, {req, " pop"}, DW'(pop), DW'(exp_pop));
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_valid == 1'b1, {req, " R3 valid"}, DW'(rd_valid), 32'd1);
        chk(rd_data == exp, {req, " data"}, rd_data, exp);
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            wr_cnt[c] = 0;
            rd_cnt[c] = 0;
            hold_m[c] = '0;
        end
        rst = 1'b1;
        bus_reset = 1'b0;
        rd_en = 1'b0;
        rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_data == '0, "R10 reset data", rd_data, '0);
        chk(rd_valid == 1'b0, "R10 reset valid", DW'(rd_valid), '0);
        chk(pop == '0, "R10 reset pop", DW'(pop), '0);

        // Empty reads before any pop
        for (int c = 0; c < NCH; c++)
            do_read(8'(8'h80 + 4 * c), "R6 empty-after-reset");

        // Different fill levels per FIFO
        wr_cnt[0] = 3;
        wr_cnt[1] = 2;
        wr_cnt[2] = 1;
        for (int k = 0; k < 4; k++) do_read(8'h80, "R2/R4 ch0 drain");
        for (int k = 0; k < 3; k++) do_read(8'h84, "R2/R4 ch1 drain");
        for (int k = 0; k < 2; k++) do_read(8'h88, "R2/R4 ch2 drain");
        do_read(8'h80, "R5 ch0 hold kept");
        do_read(8'h84, "R5 ch1 hold kept");

        // Interleaved reads across channels
        for (int c = 0; c < NCH; c++) wr_cnt[c] += 2;
        for (int k = 0; k < 9; k++) do_read(8'(8'h80 + 4 * (k % 3)), "R1/R5 interleave");

        // Sweep every offset with one word in each FIFO
        for (int c = 0; c < NCH; c++) wr_cnt[c] += 1;
        for (int a = 0; a < 256; a++) do_read(8'(a), "R1/R8 sweep");
        for (int c = 0; c < NCH; c++)
            do_read(8'(8'h80 + 4 * c), "R8 hold after sweep");

        // No pop without read strobe
        wr_cnt[0] += 1;
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            rd_en = 1'b0;
            rd_addr = 8'(8'h80 + a);
            #1;
            chk(pop == '0, "R9 idle pop", DW'(pop), '0);
        end

        // Bus reset with a concurrent read
        @(negedge clk);
        bus_reset = 1'b1;
        rd_en = 1'b1;
        rd_addr = 8'h80;
        #1;
        chk(pop == '0, "R7 pop during bus reset", DW'(pop), '0);
        @(negedge clk);
        bus_reset = 1'b0;
        rd_en = 1'b0;
        chk(rd_valid == 1'b0, "R7 valid after bus reset", DW'(rd_valid), '0);
        chk(rd_data == '0, "R7 data after bus reset", rd_data, '0);
        for (int c = 0; c < NCH; c++) hold_m[c] = '0;
        do_read(8'h84, "R7 ch1 cleared");
        do_read(8'h88, "R7 ch2 cleared");
        do_read(8'h80, "R7 ch0 pop after bus reset");
        do_read(8'h80, "R7 ch0 hold after bus reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule